// File: doc/BRIEF.md
# UART Receive Character FIFO with Trigger Interrupt

This block buffers received characters on the receive side of a UART. Each entry is 12 bits wide: the character in bits [7:0] and four error flags in bits [11:8], where bit 8 is framing error, bit 9 is parity error, bit 10 is break and bit 11 is overrun. Entries come in either from the serial deserializer or from the internal loopback path. They are drained by reads of the data register. The block drives the full and empty flags, a receive interrupt request and a ready signal that tells the deserializer it may deliver a character.

The buffer is circular and runs in one of two modes. In FIFO mode it uses all `DEPTH` slots (16 by default). In character mode it acts as a single holding register. The mode can change at run time, and every change flushes the buffer. The receive interrupt is tied to a trigger level, which is 1 after reset and goes back to 1 on every configuration write. The interrupt sets when a write makes the fill count equal to the trigger. It clears when a read leaves the count one below the trigger. The error flags of each entry that is read are captured into a status output for the receive status register.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `rx_irq_o`=0, `ready_o`=1 and `rx_err_o`=0.
- R2: With `fifo_en_i`=1, up to DEPTH entries are held and are read back in the order they were written. `empty_o` is never high together with `full_o`.
- R3: `full_o` rises when a write brings the count to the current depth. While it is high, `ready_o` is 0 and further writes are dropped. Any data read, whether or not it removes an entry, clears `full_o` on the next edge.
- R4: With `fifo_en_i`=0, the block holds at most one entry. One write sets `full_o`, and a second write is dropped.
- R5: A read while empty shows the entry at the read pointer on `rd_entry_o` and leaves the count unchanged. `empty_o` stays 1, and the next written entry is the next one read.
- R6: `rx_irq_o` sets on the edge where a write makes the count equal to the trigger level. It clears on the edge where a read leaves the count at trigger minus one. Reads that leave a larger count keep it set.
- R7: The trigger level is 1 after reset and is restored to 1 by each `cfg_wr_i` pulse.
- R8: While `loopback_i`=1, external characters and external breaks are ignored. While `loopback_i`=0, loopback characters and loopback breaks are ignored.
- R9: A break event from the active source is stored as an entry with only bit 10 set (value 12'h400).
- R10: `rx_err_o` holds bits [11:8] of the entry shown on `rd_entry_o` during the most recent `rd_i` cycle.
- R11: A `flush_i` pulse, or any change of `fifo_en_i`, empties the buffer. It resets the read pointer, sets `empty_o`, and clears `full_o` and `rx_irq_o`.
- R12: A read and a write in the same cycle, when the buffer is not full, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = full-depth mode, 0 = single-entry mode |
| loopback_i | input | 1 | Selects the loopback path as the write source |
| cfg_wr_i | input | 1 | Line control or level register write strobe; reloads the trigger |
| flush_i | input | 1 | Empties the buffer |
| ext_valid_i | input | 1 | Deserializer delivers an entry |
| ext_entry_i | input | 12 | Deserializer entry {err[3:0], data[7:0]} |
| ext_break_i | input | 1 | External break event |
| lb_valid_i | input | 1 | Loopback character strobe |
| lb_data_i | input | 8 | Loopback character |
| lb_break_i | input | 1 | Loopback break event |
| rd_i | input | 1 | Data register read strobe |
| rd_entry_o | output | 12 | Entry at the read pointer |
| rx_err_o | output | 4 | Error bits of the last entry read |
| full_o | output | 1 | Full flag |
| empty_o | output | 1 | Empty flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| ready_o | output | 1 | Buffer can accept an entry |

## Verification
Several properties are checked on every cycle by assertions:
- the fill count never passes the depth, and stays at one or below in single-entry mode;
- the full flag blocks acceptance, and full and empty are never high together;
- the source that is not selected never produces a write;
- an empty read keeps the buffer empty, and a flush empties it;
- every rise of the interrupt follows an accepted write, and every fall follows a read or a flush.

Other behaviour only the bench scenarios can show: the data order over a full 16-entry pass, the stale entry returned by an empty read, break encoding, error capture, and how the interrupt behaves at each count across fill and drain.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ERR_W   = 4;
  localparam int unsigned ENTRY_W = DATA_W + ERR_W;
  localparam int unsigned BRK_BIT = DATA_W + 2;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [ERR_W-1:0]   err_t;

  function automatic entry_t break_entry();
    entry_t e;
    e = '0;
    e[BRK_BIT] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/rx_fifo_src.sv
module rx_fifo_src
  import uart_rx_fifo_pkg::*;
(
  input  logic                loopback_i,
  input  logic                ext_valid_i,
  input  entry_t              ext_entry_i,
  input  logic                ext_break_i,
  input  logic                lb_valid_i,
  input  logic [DATA_W-1:0]   lb_data_i,
  input  logic                lb_break_i,
  output logic                wr_req_o,
  output entry_t              wr_entry_o
);
  // break wins over a character in the same cycle
  always_comb begin
    wr_req_o   = 1'b0;
    wr_entry_o = '0;
    if (loopback_i) begin
      if (lb_break_i) begin
        wr_req_o   = 1'b1;
        wr_entry_o = break_entry();
      end else if (lb_valid_i) begin
        wr_req_o   = 1'b1;
        wr_entry_o = {{ERR_W{1'b0}}, lb_data_i};
      end
    end else begin
      if (ext_break_i) begin
        wr_req_o   = 1'b1;
        wr_entry_o = break_entry();
      end else if (ext_valid_i) begin
        wr_req_o   = 1'b1;
        wr_entry_o = ext_entry_i;
      end
    end
  end
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  entry_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output entry_t        rdata_o
);
  entry_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    entry_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (we_i && (waddr_i == AW'(g)))        slot_q <= wdata_i;
    end
    assign slots[g] = slot_q;
  end

  assign rdata_o = slots[raddr_i];
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          flush_i,
  input  logic          wr_req_i,
  input  logic          rd_i,
  output logic          wr_acc_o,
  output logic          rd_dec_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic          flush_o,
  output logic          mode_chg_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ready_o
);
  logic          fifo_en_q;
  logic [CW-1:0] count_q, count_n, depth_cur;
  logic [AW-1:0] rp_q, rp_n, mask;
  logic          full_q, empty_q;

  assign mode_chg_o = fifo_en_i ^ fifo_en_q;
  assign flush_o    = flush_i | mode_chg_o;
  assign depth_cur  = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign mask       = fifo_en_i ? AW'(DEPTH - 1) : '0;

  assign ready_o  = (count_q < depth_cur) && !mode_chg_o;
  assign wr_acc_o = wr_req_i && ready_o && !flush_i;
  assign rd_dec_o = rd_i && (count_q != '0) && !flush_o;

  assign count_n = count_q - CW'(rd_dec_o) + CW'(wr_acc_o);
  assign rp_n    = (rp_q + AW'(rd_dec_o)) & mask;
  assign waddr_o = (rp_q + count_q[AW-1:0]) & mask;
  assign raddr_o = rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      count_q   <= '0;
      rp_q      <= '0;
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
    end else begin
      fifo_en_q <= fifo_en_i;
      if (flush_o) begin
        count_q <= '0;
        rp_q    <= '0;
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end else begin
        count_q <= count_n;
        rp_q    <= rp_n;
        empty_q <= (count_n == '0);
        if (wr_acc_o && (count_n == depth_cur)) full_q <= 1'b1;
        else if (rd_i)                          full_q <= 1'b0;
      end
    end
  end

  assign count_o = count_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int unsigned CW       = 5,
  parameter int unsigned TRIG_LVL = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic          flush_i,
  input  logic          wr_acc_i,
  input  logic          rd_dec_i,
  input  logic [CW-1:0] count_i,
  output logic          irq_o
);
  logic [CW-1:0] trig_q, cnt_after_rd;
  logic          set_hit, clr_hit, irq_q;

  // a read and a write in one cycle act as read-then-write
  assign cnt_after_rd = count_i - CW'(rd_dec_i);
  assign set_hit = wr_acc_i && ((cnt_after_rd + CW'(1)) == trig_q);
  assign clr_hit = rd_dec_i && (cnt_after_rd == (trig_q - CW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= CW'(TRIG_LVL);
      irq_q  <= 1'b0;
    end else begin
      if (cfg_wr_i) trig_q <= CW'(TRIG_LVL);
      if (flush_i)      irq_q <= 1'b0;
      else if (set_hit) irq_q <= 1'b1;
      else if (clr_hit) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned TRIG_LVL = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               loopback_i,
  input  logic               cfg_wr_i,
  input  logic               flush_i,
  input  logic               ext_valid_i,
  input  logic [11:0]        ext_entry_i,
  input  logic               ext_break_i,
  input  logic               lb_valid_i,
  input  logic [7:0]         lb_data_i,
  input  logic               lb_break_i,
  input  logic               rd_i,
  output logic [11:0]        rd_entry_o,
  output logic [3:0]         rx_err_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               rx_irq_o,
  output logic               ready_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic          wr_req_w, wr_acc_w, rd_dec_w, flush_w, mode_chg_w;
  entry_t        wr_entry_w, rd_entry_w;
  logic [AW-1:0] waddr_w, raddr_w;
  logic [CW-1:0] count_w;
  err_t          err_q;

  rx_fifo_src u_src (
    .loopback_i (loopback_i),
    .ext_valid_i(ext_valid_i),
    .ext_entry_i(ext_entry_i),
    .ext_break_i(ext_break_i),
    .lb_valid_i (lb_valid_i),
    .lb_data_i  (lb_data_i),
    .lb_break_i (lb_break_i),
    .wr_req_o   (wr_req_w),
    .wr_entry_o (wr_entry_w)
  );

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .flush_i   (flush_i),
    .wr_req_i  (wr_req_w),
    .rd_i      (rd_i),
    .wr_acc_o  (wr_acc_w),
    .rd_dec_o  (rd_dec_w),
    .waddr_o   (waddr_w),
    .raddr_o   (raddr_w),
    .count_o   (count_w),
    .flush_o   (flush_w),
    .mode_chg_o(mode_chg_w),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .ready_o   (ready_o)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_acc_w),
    .waddr_i(waddr_w),
    .wdata_i(wr_entry_w),
    .raddr_i(raddr_w),
    .rdata_o(rd_entry_w)
  );

  rx_fifo_irq #(.CW(CW), .TRIG_LVL(TRIG_LVL)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_wr_i(cfg_wr_i),
    .flush_i (flush_w),
    .wr_acc_i(wr_acc_w),
    .rd_dec_i(rd_dec_w),
    .count_i (count_w),
    .irq_o   (rx_irq_o)
  );

  // status capture: every read, empty or not, latches the shown error bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= '0;
    else if (rd_i) err_q <= rd_entry_w[ENTRY_W-1:DATA_W];
  end

  assign rd_entry_o = rd_entry_w;
  assign rx_err_o   = err_q;
endmodule

// File: rtl/rx_fifo_chk.sv
module rx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          loopback_i,
  input logic          flush_i,
  input logic          rd_i,
  input logic          ext_valid_i,
  input logic          ext_break_i,
  input logic          lb_valid_i,
  input logic          lb_break_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          ready_o,
  input logic          rx_irq_o,
  input logic          wr_acc,
  input logic          rd_dec,
  input logic          flush_eff,
  input logic          mode_chg,
  input logic [CW-1:0] count
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (!ready_o && !wr_acc));

  assert_full_empty_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_single_depth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !mode_chg) |-> (count <= CW'(1)));

  assert_empty_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !ext_valid_i && !ext_break_i && !lb_valid_i && !lb_break_i)
      |=> empty_o);

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(wr_acc));

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(rd_dec || flush_eff));

  assert_lb_ignores_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loopback_i && !lb_valid_i && !lb_break_i) |-> !wr_acc);

  assert_ext_ignores_lb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loopback_i && !ext_valid_i && !ext_break_i) |-> !wr_acc);

  assert_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !full_o && !rx_irq_o));
endmodule

bind uart_rx_fifo rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .loopback_i (loopback_i),
  .flush_i    (flush_i),
  .rd_i       (rd_i),
  .ext_valid_i(ext_valid_i),
  .ext_break_i(ext_break_i),
  .lb_valid_i (lb_valid_i),
  .lb_break_i (lb_break_i),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .ready_o    (ready_o),
  .rx_irq_o   (rx_irq_o),
  .wr_acc     (wr_acc_w),
  .rd_dec     (rd_dec_w),
  .flush_eff  (flush_w),
  .mode_chg   (mode_chg_w),
  .count      (count_w)
);

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_en_i = 1'b0, loopback_i = 1'b0, cfg_wr_i = 1'b0, flush_i = 1'b0;
  logic        ext_valid_i = 1'b0, ext_break_i = 1'b0;
  logic [11:0] ext_entry_i = '0;
  logic        lb_valid_i = 1'b0, lb_break_i = 1'b0;
  logic [7:0]  lb_data_i = '0;
  logic        rd_i = 1'b0;
  logic [11:0] rd_entry_o;
  logic [3:0]  rx_err_o;
  logic        full_o, empty_o, rx_irq_o, ready_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int mdl_depth = 1;
  logic [11:0] sb[$];
  logic [11:0] stale = '0;

  always #2 clk = ~clk;

  uart_rx_fifo u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .loopback_i(loopback_i),
    .cfg_wr_i(cfg_wr_i), .flush_i(flush_i), .ext_valid_i(ext_valid_i),
    .ext_entry_i(ext_entry_i), .ext_break_i(ext_break_i), .lb_valid_i(lb_valid_i),
    .lb_data_i(lb_data_i), .lb_break_i(lb_break_i), .rd_i(rd_i),
    .rd_entry_o(rd_entry_o), .rx_err_o(rx_err_o), .full_o(full_o), .empty_o(empty_o),
    .rx_irq_o(rx_irq_o), .ready_o(ready_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver tasks: start and end on a falling edge, push expected items
  task automatic wr_ext(input logic [11:0] e);
    ext_valid_i = 1'b1; ext_entry_i = e;
    if (!loopback_i && sb.size() < mdl_depth) sb.push_back(e);
    @(negedge clk);
    ext_valid_i = 1'b0;
  endtask

  task automatic brk_ext();
    ext_break_i = 1'b1;
    if (!loopback_i && sb.size() < mdl_depth) sb.push_back(12'h400);
    @(negedge clk);
    ext_break_i = 1'b0;
  endtask

  task automatic wr_lb(input logic [7:0] d);
    lb_valid_i = 1'b1; lb_data_i = d;
    if (loopback_i && sb.size() < mdl_depth) sb.push_back({4'h0, d});
    @(negedge clk);
    lb_valid_i = 1'b0;
  endtask

  // monitor side: pop expected entry and compare what the design presents
  task automatic rd_cmp(input string req);
    logic [11:0] exp;
    rd_i = 1'b1;
    if (sb.size() > 0) exp = sb.pop_front(); else exp = stale;
    stale = exp;
    check(req, "rd_entry", rd_entry_o, exp);
    @(negedge clk);
    rd_i = 1'b0;
    check("R10", "rx_err", rx_err_o, exp[11:8]);
  endtask

  task automatic rdwr(input logic [11:0] e);
    logic [11:0] exp;
    bit acc;
    acc = sb.size() < mdl_depth;
    rd_i = 1'b1; ext_valid_i = 1'b1; ext_entry_i = e;
    exp = sb.pop_front();
    if (acc) sb.push_back(e);
    check("R12", "rd_entry", rd_entry_o, exp);
    @(negedge clk);
    rd_i = 1'b0; ext_valid_i = 1'b0;
  endtask

  task automatic set_mode(input logic en);
    if (en != fifo_en_i) sb.delete();
    fifo_en_i = en; mdl_depth = en ? 16 : 1;
    @(negedge clk);
  endtask

  task automatic do_flush();
    flush_i = 1'b1; sb.delete();
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "empty", empty_o, 1);
    check("R1", "full", full_o, 0);
    check("R1", "irq", rx_irq_o, 0);
    check("R1", "ready", ready_o, 1);
    check("R1", "rx_err", rx_err_o, 0);

    // full-depth pass
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) begin
      wr_ext({4'(i) & 4'b1011, 8'(i * 17 + 3)});
      if (i == 0) check("R6", "irq after first write", rx_irq_o, 1);
      if (i == 14) check("R2", "full before depth", full_o, 0);
    end
    check("R2", "full at depth", full_o, 1);
    check("R3", "ready when full", ready_o, 0);
    wr_ext(12'h0EE);  // dropped
    rd_cmp("R2");
    check("R3", "full cleared by read", full_o, 0);
    for (int i = 1; i < 15; i++) rd_cmp("R2");
    check("R6", "irq held at count 1", rx_irq_o, 1);
    rd_cmp("R3");  // the sixteenth entry, not the dropped one
    check("R6", "irq cleared at count 0", rx_irq_o, 0);
    check("R2", "empty after drain", empty_o, 1);

    // simultaneous read and write
    wr_ext(12'h155);
    rdwr(12'h2AA);
    check("R12", "not empty", empty_o, 0);
    rd_cmp("R12");
    check("R12", "empty", empty_o, 1);

    // source selection
    loopback_i = 1'b1;
    wr_ext(12'h011);
    brk_ext();
    check("R8", "ext ignored in loopback", empty_o, 1);
    wr_lb(8'h5C);
    rd_cmp("R8");
    loopback_i = 1'b0;
    wr_lb(8'h33);
    check("R8", "lb ignored outside loopback", empty_o, 1);

    // break entry
    brk_ext();
    rd_cmp("R9");
    check("R9", "break status bit", rx_err_o[2], 1);

    // single-entry mode and empty read
    set_mode(1'b0);
    wr_ext(12'h3A1);
    check("R4", "full after one", full_o, 1);
    wr_ext(12'h0B2);  // dropped
    rd_cmp("R4");
    rd_cmp("R5");     // empty: stale 3A1
    check("R5", "still empty", empty_o, 1);
    check("R5", "irq stays low", rx_irq_o, 0);
    wr_ext(12'h0C3);
    rd_cmp("R5");

    // flush by pulse and by mode change
    set_mode(1'b1);
    wr_ext(12'h001); wr_ext(12'h002); wr_ext(12'h003);
    rd_cmp("R11");
    do_flush();
    check("R11", "empty after flush", empty_o, 1);
    check("R11", "irq after flush", rx_irq_o, 0);
    wr_ext(12'h0D4);
    rd_cmp("R11");
    wr_ext(12'h0E5); wr_ext(12'h0F6);
    set_mode(1'b0);
    check("R11", "empty after mode change", empty_o, 1);
    check("R11", "full after mode change", full_o, 0);

    // trigger reload
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    wr_ext(12'h07A);
    check("R7", "irq at trigger 1", rx_irq_o, 1);
    rd_cmp("R7");
    check("R7", "irq cleared", rx_irq_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule